// File: doc/BRIEF.md
# Run-Length Hysteresis Detector

This block is a clocked Moore state machine. It watches a single serial bit and drives one output level with asymmetric hysteresis. While the level is low, the block counts consecutive ones. The level rises on the clock edge that samples the eighth unbroken one. While the level is high, the block counts consecutive zeros. The level falls on the edge that samples the fourth unbroken zero. A single opposite bit restarts whichever run is being counted.

Each state carries an explicit code. The machine has twelve states: eight on the rising path (ones counted 0..7) and four on the falling path (zeros counted 0..3). The current code is brought out on a port so it can be observed. A parameter selects binary or one-hot codes. The next-state logic and the output decode are separate pieces that work on a state index decoded from the stored code. Any code outside the twelve legal ones sends the machine back to the reset state on the next edge.

The input is a plain level that is sampled once per clock. The block has no data stream with flow control, so no valid/ready pair appears at its edge.

Top module: `rl_hyst_detector`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, leaves `detect_level` low and `state_code` at 0, the idle-low state.
- R2: `detect_level` goes high on the rising edge that samples `sample_bit`=1 for the 8th consecutive time while low, and is visible right after that edge. A run of only 7 ones leaves it low.
- R3: While `detect_level` is low, a sampled 0 returns the ones count to zero (`state_code` becomes 0) and the level stays low.
- R4: While high, `detect_level` goes low on the edge that samples the 4th consecutive 0. A run of only 3 zeros leaves it high.
- R5: While high, a sampled 1 returns the zeros count to zero (`state_code` becomes 8) and the level stays high.
- R6: Ones that continue after the level has risen keep the machine in its high-idle state (`state_code` 8) with the level high.
- R7: With the default binary encoding, `state_code` equals k while low with k ones counted (0..7), and 8+j while high with j zeros counted (0..3). No other value ever appears.
- R8: `detect_level` is a Moore output: it is high exactly in the eight-and-above (high-path) states and depends on no input of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge samples `sample_bit` |
| rst | input | 1 | Synchronous reset, active high |
| sample_bit | input | 1 | Serial bit being watched |
| detect_level | output | 1 | Hysteresis output level |
| state_code | output | CODE_W (4 by default) | Current stored state code |

## Verification
The assertions take for granted that `sample_bit` holds a known 0 or 1 at every rising edge, and that `rst` is high at the first edge so the state starts legal. The bench holds reset for several cycles before it drives anything. It changes `sample_bit` only on falling edges and only to 0 or 1. Its random part is built from runs of one value with lengths from 1 to 11, which spans both thresholds from each side.

// File: rtl/rl_hyst_pkg.sv
package rl_hyst_pkg;

  // Selects how a state index is stored in the state register.
  typedef enum logic {
    ENC_BINARY = 1'b0,
    ENC_ONEHOT = 1'b1
  } rl_hyst_enc_e;

endpackage

// File: rtl/rl_hyst_encode.sv
module rl_hyst_encode
  import rl_hyst_pkg::*;
#(
  parameter rl_hyst_enc_e ENC        = ENC_BINARY,
  parameter int           NUM_STATES = 12,
  parameter int           IDX_W      = 4,
  parameter int           CODE_W     = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code
);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      always_comb begin
        code = '0;
        for (int i = 0; i < NUM_STATES; i++) begin
          if (idx == IDX_W'(i)) code[i] = 1'b1;
        end
      end
    end else begin : g_binary
      assign code = CODE_W'(idx);
    end
  endgenerate

endmodule

// File: rtl/rl_hyst_decode.sv
module rl_hyst_decode
  import rl_hyst_pkg::*;
#(
  parameter rl_hyst_enc_e ENC        = ENC_BINARY,
  parameter int           NUM_STATES = 12,
  parameter int           IDX_W      = 4,
  parameter int           CODE_W     = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx,
  output logic              legal
);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      always_comb begin
        idx   = '0;
        legal = $onehot(code);
        for (int i = 0; i < NUM_STATES; i++) begin
          if (code[i]) idx = IDX_W'(i);
        end
      end
    end else begin : g_binary
      assign idx   = IDX_W'(code);
      assign legal = (code < CODE_W'(NUM_STATES));
    end
  endgenerate

endmodule

// File: rtl/rl_hyst_next.sv
module rl_hyst_next #(
  parameter int RISE_RUN = 8,
  parameter int FALL_RUN = 4,
  parameter int IDX_W    = 4
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_legal,
  input  logic             sample_bit,
  output logic [IDX_W-1:0] nxt_idx
);

  localparam logic [IDX_W-1:0] IDLE_LOW  = '0;
  localparam logic [IDX_W-1:0] LAST_LOW  = IDX_W'(RISE_RUN - 1);
  localparam logic [IDX_W-1:0] IDLE_HIGH = IDX_W'(RISE_RUN);
  localparam logic [IDX_W-1:0] LAST_HIGH = IDX_W'(RISE_RUN + FALL_RUN - 1);

  always_comb begin
    nxt_idx = IDLE_LOW;
    if (!cur_legal) begin
      nxt_idx = IDLE_LOW;
    end else if (cur_idx < IDLE_HIGH) begin
      // low path: count ones, any zero restarts
      if (sample_bit) begin
        nxt_idx = (cur_idx == LAST_LOW) ? IDLE_HIGH : cur_idx + 1'b1;
      end else begin
        nxt_idx = IDLE_LOW;
      end
    end else begin
      // high path: count zeros, any one restarts
      if (sample_bit) begin
        nxt_idx = IDLE_HIGH;
      end else begin
        nxt_idx = (cur_idx == LAST_HIGH) ? IDLE_LOW : cur_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rl_hyst_detector.sv
module rl_hyst_detector
  import rl_hyst_pkg::*;
#(
  parameter int           RISE_RUN   = 8,
  parameter int           FALL_RUN   = 4,
  parameter rl_hyst_enc_e ENC        = ENC_BINARY,
  parameter int           NUM_STATES = RISE_RUN + FALL_RUN,
  parameter int           IDX_W      = $clog2(NUM_STATES),
  parameter int           CODE_W     = (ENC == ENC_ONEHOT) ? NUM_STATES : IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_bit,
  output logic              detect_level,
  output logic [CODE_W-1:0] state_code
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] reset_code;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  nxt_idx;
  logic              cur_legal;

  rl_hyst_decode #(
    .ENC(ENC), .NUM_STATES(NUM_STATES), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_dec (
    .code (code_q),
    .idx  (cur_idx),
    .legal(cur_legal)
  );

  rl_hyst_next #(
    .RISE_RUN(RISE_RUN), .FALL_RUN(FALL_RUN), .IDX_W(IDX_W)
  ) u_next (
    .cur_idx   (cur_idx),
    .cur_legal (cur_legal),
    .sample_bit(sample_bit),
    .nxt_idx   (nxt_idx)
  );

  rl_hyst_encode #(
    .ENC(ENC), .NUM_STATES(NUM_STATES), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_enc_next (
    .idx (nxt_idx),
    .code(code_d)
  );

  rl_hyst_encode #(
    .ENC(ENC), .NUM_STATES(NUM_STATES), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_enc_reset (
    .idx ('0),
    .code(reset_code)
  );

  always_ff @(posedge clk) begin
    if (rst) code_q <= reset_code;
    else     code_q <= code_d;
  end

  // Moore output: depends only on the stored state
  assign detect_level = cur_legal && (cur_idx >= IDX_W'(RISE_RUN));
  assign state_code   = code_q;

endmodule

// File: rtl/rl_hyst_checker.sv
module rl_hyst_checker #(
  parameter int RISE_RUN = 8,
  parameter int FALL_RUN = 4,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_bit,
  input logic             detect_level,
  input logic [IDX_W-1:0] cur_idx
);

  localparam int NUM = RISE_RUN + FALL_RUN;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cur_idx == '0 && !detect_level));

  assert_rise_after_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_level) |-> ($past(sample_bit) && $past(cur_idx) == IDX_W'(RISE_RUN - 1)));

  assert_zero_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (!detect_level && !sample_bit) |=> (cur_idx == '0 && !detect_level));

  assert_fall_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(detect_level) |-> (!$past(sample_bit) && $past(cur_idx) == IDX_W'(NUM - 1)));

  assert_one_rearms_high_R5: assert property (@(posedge clk) disable iff (rst)
    (detect_level && sample_bit) |=> (detect_level && cur_idx == IDX_W'(RISE_RUN)));

  assert_index_legal_R7: assert property (@(posedge clk) disable iff (rst)
    cur_idx < IDX_W'(NUM));

  assert_level_from_state_R8: assert property (@(posedge clk) disable iff (rst)
    detect_level == (cur_idx >= IDX_W'(RISE_RUN)));

endmodule

bind rl_hyst_detector rl_hyst_checker #(
  .RISE_RUN(RISE_RUN), .FALL_RUN(FALL_RUN), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sample_bit  (sample_bit),
  .detect_level(detect_level),
  .cur_idx     (cur_idx)
);

// File: tb/rl_hyst_detector_tb.sv
module rl_hyst_detector_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_bit = 1'b0;
  logic       detect_level;
  logic [3:0] state_code;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // reference model state
  bit ref_high = 1'b0;
  int ref_run  = 0;

  bit    exp_lvl_q[$];
  int    exp_code_q[$];
  string exp_tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  rl_hyst_detector u_dut (
    .clk         (clk),
    .rst         (rst),
    .sample_bit  (sample_bit),
    .detect_level(detect_level),
    .state_code  (state_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one bit, advance the run-counting model, queue expectation
  task automatic drive(input bit b, input string tag);
    @(negedge clk);
    sample_bit = b;
    if (!ref_high) begin
      if (b) begin
        ref_run++;
        if (ref_run == 8) begin ref_high = 1'b1; ref_run = 0; end
      end else ref_run = 0;
    end else begin
      if (!b) begin
        ref_run++;
        if (ref_run == 4) begin ref_high = 1'b0; ref_run = 0; end
      end else ref_run = 0;
    end
    exp_lvl_q.push_back(ref_high);
    exp_code_q.push_back(ref_high ? 8 + ref_run : ref_run);
    exp_tag_q.push_back(tag);
  endtask

  task automatic drive_run(input bit b, input int n, input string tag);
    for (int i = 0; i < n; i++) drive(b, tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #5;
    if (exp_lvl_q.size() > 0) begin
      bit    el;
      int    ec;
      string t;
      el = exp_lvl_q.pop_front();
      ec = exp_code_q.pop_front();
      t  = exp_tag_q.pop_front();
      check(detect_level == el, {t, " level"}, int'(detect_level), int'(el));
      check(int'(state_code) == ec, {t, " code R7"}, int'(state_code), ec);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!detect_level, "R1 reset level", int'(detect_level), 0);
    check(state_code == 4'd0, "R1 reset code", int'(state_code), 0);
    rst = 1'b0;

    drive_run(1'b1, 7, "R2 seven ones");
    drive(1'b0, "R3 zero restarts");
    drive_run(1'b1, 3, "R3 partial ones");
    drive(1'b0, "R3 zero restarts again");
    drive_run(1'b1, 8, "R2 eight ones");
    drive_run(1'b1, 5, "R6 ones held high");
    drive_run(1'b0, 3, "R4 three zeros");
    drive(1'b1, "R5 one rearms");
    drive_run(1'b0, 3, "R4 three zeros again");
    drive(1'b0, "R4 fourth zero");
    drive_run(1'b0, 2, "R3 zeros while low");

    for (int r = 0; r < 400; r++) begin
      bit b;
      int n;
      b = 1'(r & 1);
      n = $urandom_range(1, 11);
      drive_run(b, n, "R7 R8 random runs");
    end

    drive_run(1'b0, 4, "R4 final fall");
    repeat (3) @(negedge clk);
    check(exp_lvl_q.size() == 0, "R8 scoreboard drained", exp_lvl_q.size(), 0);

    // reset from the high state
    drive_run(1'b1, 8, "R2 rise before reset");
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!detect_level, "R1 reset from high level", int'(detect_level), 0);
    check(state_code == 4'd0, "R1 reset from high code", int'(state_code), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule